// File: doc/BRIEF.md
# Transmit Clock Loss Monitor

This block watches the transmit clock of a line interface from a free-running master clock. It brings the transmit clock into the master clock domain through a synchronizer and detects its edges there. A counter measures how long the clock has gone without an edge. Once the silence lasts eight nominal transmit periods, the block declares a loss.

While the loss lasts, the block drops both line driver enables, which puts the transmit outputs in high impedance. It also requests that the oscillator reference fall back to the sync input, unless software has disabled that fallback. Each new loss sets a sticky interrupt bit. The first transmit clock edge seen after a loss ends it and releases the drivers.

An alarm simulation input forces the loss state on for as long as it is held. The master clock must keep running for the monitor to work.

Top module: `txclk_loss_mon`

## Requirements
- R1: During and right after reset, loss_o is 0, drv_en_o is 2'b11, ref_sync_o is 0 and irq_o is 0.
- R2: loss_o rises only when the silence counter has reached its limit of MISS_PERIODS*PERIOD_CYC master cycles, or when alarm_sim_i is high.
- R3: Every synchronized transmit clock edge restarts the silence count. With defaults (limit 64), after the last edge loss_o is still 0 sixty master cycles later and is 1 seventy-five cycles later.
- R4: drv_en_o is 2'b00 (both outputs high impedance) while loss_o is 1, and 2'b11 while loss_o is 0.
- R5: While loss_o is 1 and alarm_sim_i is 0, the first synchronized transmit clock edge clears loss_o on the next master cycle, which is within six master cycles of the edge at the pin.
- R6: Any 0-to-1 change of the loss state sets irq_o in the same cycle.
- R7: irq_o stays 1 until irq_clr_i is pulsed; a loss that is still active does not set it again.
- R8: A one-cycle irq_clr_i pulse clears irq_o on the next cycle, unless a new loss rises in that same cycle.
- R9: ref_sync_o is 1 exactly when loss_o is 1 and ref_sw_dis_i is 0.
- R10: While alarm_sim_i is 1, loss_o is 1 from the next cycle on, whatever the transmit clock does.
- R11: The silence counter saturates at its limit and never exceeds it.
- R12: A transmit clock that keeps toggling at or below its nominal period never raises loss_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Free-running master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txclk_i | input | 1 | Transmit clock under watch (asynchronous) |
| alarm_sim_i | input | 1 | Forces the loss state while high |
| ref_sw_dis_i | input | 1 | Blocks the reference fallback to the sync input |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the sticky interrupt |
| loss_o | output | 1 | Transmit clock loss status |
| drv_en_o | output | LANES | Line driver enables, 0 means high impedance |
| ref_sync_o | output | 1 | Request to switch the oscillator reference to sync |
| irq_o | output | 1 | Sticky interrupt status |

## Verification
The transmit clock is driven in three ways: free-running at a period a little longer than nominal, stopped immediately after a known edge, and restarted while the block is in loss. The running case shows that normal toggling never times out. The stopped case places the detection between an early bound and a late bound, so both a timeout that fires too soon and one that never fires are caught. The restart case measures how fast the block recovers. Alarm simulation and the fallback disable are combined with running and stopped clocks so that forced loss, natural loss and the blocked reference request each leave different output patterns.

// File: rtl/txcl_pkg.sv
package txcl_pkg;

    typedef enum logic [1:0] {
        EDGE_BOTH    = 2'd0,
        EDGE_RISING  = 2'd1,
        EDGE_FALLING = 2'd2
    } edge_sel_e;

    typedef struct packed {
        logic loss;
        logic irq;
    } ctrl_st_t;

endpackage

// File: rtl/txcl_sync.sv
module txcl_sync
    import txcl_pkg::*;
#(
    parameter int        STAGES   = 2,
    parameter edge_sel_e EDGE_SEL = EDGE_BOTH
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic level_o,
    output logic edge_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;
    logic newer, older;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign newer   = chain_q[STAGES-1];
    assign older   = chain_q[STAGES];
    assign level_o = newer;

    generate
        if (EDGE_SEL == EDGE_RISING) begin : g_rise
            assign edge_o = newer & ~older;
        end else if (EDGE_SEL == EDGE_FALLING) begin : g_fall
            assign edge_o = ~newer & older;
        end else begin : g_both
            assign edge_o = newer ^ older;
        end
    endgenerate

endmodule

// File: rtl/txcl_timer.sv
module txcl_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic edge_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (edge_i)            cnt_d = '0;
        else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == LIM);

    // R11: the counter never runs past its limit
    p_cnt_bounded_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIM);

    // R3: an edge restarts the silence count
    p_edge_restarts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_i |=> (cnt_q == '0));

endmodule

// File: rtl/txcl_ctrl.sv
module txcl_ctrl
    import txcl_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_i,
    input  logic             expired_i,
    input  logic             alarm_i,
    input  logic             ref_dis_i,
    input  logic             irq_clr_i,
    output logic             loss_o,
    output logic             irq_o,
    output logic             ref_sync_o,
    output logic [LANES-1:0] drv_en_o
);
    ctrl_st_t st_d, st_q;
    logic     loss_rise;

    always_comb begin
        st_d      = st_q;
        st_d.loss = alarm_i | (~edge_i & (st_q.loss | expired_i));
        loss_rise = st_d.loss & ~st_q.loss;
        st_d.irq  = loss_rise | (st_q.irq & ~irq_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign loss_o     = st_q.loss;
    assign irq_o      = st_q.irq;
    assign ref_sync_o = st_q.loss & ~ref_dis_i;
    assign drv_en_o   = {LANES{~st_q.loss}};

    // R2: loss needs an expired count or the alarm simulation
    p_loss_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.loss) |-> $past(expired_i || alarm_i));

    // R5: an edge ends a natural loss
    p_edge_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.loss && edge_i && !alarm_i) |=> !st_q.loss);

    // R10: alarm simulation forces loss
    p_alarm_forces_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alarm_i |=> st_q.loss);

    // R6: a new loss sets the interrupt
    p_irq_on_loss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.loss) |-> st_q.irq);

    // R7: the interrupt is sticky
    p_irq_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.irq && !irq_clr_i) |=> st_q.irq);

endmodule

// File: rtl/txclk_loss_mon.sv
module txclk_loss_mon
    import txcl_pkg::*;
#(
    parameter int        PERIOD_CYC   = 8,
    parameter int        MISS_PERIODS = 8,
    parameter int        SYNC_STAGES  = 2,
    parameter int        LANES        = 2,
    parameter edge_sel_e EDGE_SEL     = EDGE_BOTH
) (
    input  logic             mclk_i,
    input  logic             rst_ni,
    input  logic             txclk_i,
    input  logic             alarm_sim_i,
    input  logic             ref_sw_dis_i,
    input  logic             irq_clr_i,
    output logic             loss_o,
    output logic [LANES-1:0] drv_en_o,
    output logic             ref_sync_o,
    output logic             irq_o
);
    localparam int LIMIT = PERIOD_CYC * MISS_PERIODS;

    logic tx_level;
    logic tx_edge;
    logic expired;

    txcl_sync #(
        .STAGES   (SYNC_STAGES),
        .EDGE_SEL (EDGE_SEL)
    ) u_sync (
        .clk_i   (mclk_i),
        .rst_ni  (rst_ni),
        .async_i (txclk_i),
        .level_o (tx_level),
        .edge_o  (tx_edge)
    );

    txcl_timer #(
        .LIMIT (LIMIT)
    ) u_timer (
        .clk_i     (mclk_i),
        .rst_ni    (rst_ni),
        .edge_i    (tx_edge),
        .expired_o (expired)
    );

    txcl_ctrl #(
        .LANES (LANES)
    ) u_ctrl (
        .clk_i      (mclk_i),
        .rst_ni     (rst_ni),
        .edge_i     (tx_edge),
        .expired_i  (expired),
        .alarm_i    (alarm_sim_i),
        .ref_dis_i  (ref_sw_dis_i),
        .irq_clr_i  (irq_clr_i),
        .loss_o     (loss_o),
        .irq_o      (irq_o),
        .ref_sync_o (ref_sync_o),
        .drv_en_o   (drv_en_o)
    );

    // R1: reset leaves the drivers enabled and no loss
    p_reset_state_r1: assert property (@(posedge mclk_i)
        !rst_ni |-> (!loss_o && !irq_o && !ref_sync_o));

endmodule

// File: tb/txclk_loss_mon_bench.sv
module txclk_loss_mon_bench;
    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txclk = 1'b0;
    logic       tx_run = 1'b0;
    logic       alarm = 1'b0;
    logic       rdis = 1'b0;
    logic       clr = 1'b0;
    logic       loss, rsync, irq;
    logic [1:0] drv;
    int         checks = 0;
    int         errors = 0;

    // Each entry: {run, alarm, dis, exp_loss, exp_ref, exp_drv[1:0]}
    localparam logic [6:0] VEC [8] = '{
        7'b1_0_0_0_0_11,
        7'b0_0_0_1_1_00,
        7'b0_0_1_1_0_00,
        7'b1_0_1_0_0_11,
        7'b1_1_0_1_1_00,
        7'b1_0_0_0_0_11,
        7'b0_1_1_1_0_00,
        7'b1_0_0_0_0_11
    };

    txclk_loss_mon u_txclk_loss_mon (
        .mclk_i       (mclk),
        .rst_ni       (rst_n),
        .txclk_i      (txclk),
        .alarm_sim_i  (alarm),
        .ref_sw_dis_i (rdis),
        .irq_clr_i    (clr),
        .loss_o       (loss),
        .drv_en_o     (drv),
        .ref_sync_o   (rsync),
        .irq_o        (irq)
    );

    always #10 mclk = ~mclk;

    initial begin
        forever begin
            #83;
            if (tx_run) txclk = ~txclk;
        end
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge mclk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        wait_cyc(3);
        check("R1 loss", {3'b0, loss}, 4'h0);
        check("R1 drv", {2'b0, drv}, 4'h3);
        check("R1 ref", {3'b0, rsync}, 4'h0);
        check("R1 irq", {3'b0, irq}, 4'h0);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 after release", {loss, irq, drv}, 4'b0011);

        // table walk: R4 R9 R10 R12
        for (int i = 0; i < 8; i++) begin
            tx_run = VEC[i][6];
            alarm  = VEC[i][5];
            rdis   = VEC[i][4];
            wait_cyc(100);
            check("R10/R12 loss", {3'b0, loss}, {3'b0, VEC[i][3]});
            check("R9 ref", {3'b0, rsync}, {3'b0, VEC[i][2]});
            check("R4 drv", {2'b0, drv}, {2'b0, VEC[i][1:0]});
        end

        // R8: clear the sticky bit while the clock runs
        @(negedge mclk) clr = 1'b1;
        @(negedge mclk) clr = 1'b0;
        check("R8 irq cleared", {3'b0, irq}, 4'h0);

        // R12: long run at nominal period
        wait_cyc(300);
        check("R12 no loss", {3'b0, loss}, 4'h0);

        // R2 R3: stop right after a known edge
        @(txclk);
        tx_run = 1'b0;
        wait_cyc(60);
        check("R2 not too early", {3'b0, loss}, 4'h0);
        wait_cyc(15);
        check("R3 loss declared", {3'b0, loss}, 4'h1);
        check("R6 irq set", {3'b0, irq}, 4'h1);

        // R7: clear while loss stays, then no re-set
        @(negedge mclk) clr = 1'b1;
        @(negedge mclk) clr = 1'b0;
        check("R7 cleared during loss", {3'b0, irq}, 4'h0);
        wait_cyc(20);
        check("R7 no re-set", {3'b0, irq}, 4'h0);

        // R5: recovery on first edge
        tx_run = 1'b1;
        @(txclk);
        wait_cyc(6);
        check("R5 recovered", {3'b0, loss}, 4'h0);
        check("R5 drv on", {2'b0, drv}, 4'h3);

        // R7: a new loss sets irq, which holds after recovery
        @(txclk);
        tx_run = 1'b0;
        wait_cyc(80);
        tx_run = 1'b1;
        wait_cyc(40);
        check("R7 irq held", {loss, irq, 2'b0}, 4'b0100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule